// File: doc/BRIEF.md
# Fuse Array Read Sequencer

This block reads a run of consecutive bytes out of a one-time-programmable fuse macro. It drives the macro's control pins: an active-low chip select, a load enable, an active-low program enable and a strobe. It also drives the byte address. For every strobe it captures the macro's data byte and passes it on as a single-cycle stream beat. The beat carries the byte and its position in the run. Programming the fuses is out of scope, so the program-enable-bar pin is held inactive throughout.

A client pulses `start_i` with a start address and a byte count. The sequencer then walks through a fixed framing sequence: select the macro, power it up for a read, and per byte clear the address, set it up, pulse the strobe and release the strobe. After the last byte it deselects the macro and pulses `done_o`. Every wait is a whole number of microseconds. The parameter `CYCLES_PER_US` turns microseconds into clock cycles, and below U stands for that value.

States are `ST_IDLE`, `ST_SELECT`, `ST_POWER_UP`, `ST_ADDR_CLR`, `ST_ADDR_SET`, `ST_STROBE_HI`, `ST_STROBE_LO`, `ST_TAIL`, `ST_DESELECT` and `ST_FINISH`. The transitions are:
- IDLE→SELECT on a start with a nonzero count, or IDLE→FINISH on a start with a zero count.
- SELECT→POWER_UP after 1 cycle.
- POWER_UP→ADDR_CLR after 2U.
- ADDR_CLR→ADDR_SET after 1 cycle.
- ADDR_SET→STROBE_HI after 2U.
- STROBE_HI→STROBE_LO after 2U, sampling the data byte.
- STROBE_LO→ADDR_CLR after 2U when more bytes remain, or STROBE_LO→TAIL after the last byte.
- TAIL→DESELECT after 2U.
- DESELECT→FINISH after U.
- FINISH→IDLE after 1 cycle.

Top module: `fuse_read_seq`

## Requirements
- R1: While the block is idle, including after reset, the pins are chip select bar 1, load 0, program-enable-bar 1, strobe 0 and address 0, and `busy_o`, `done_o` and `rd_valid_o` are 0.
- R2: In the first cycle after a start with a nonzero count is accepted, chip select bar is 0 and load is 0. For the next 2U cycles, chip select bar is 0 and load is 1 while the address stays 0. Program-enable-bar stays 1 during the whole read.
- R3: Each byte begins with one cycle in which the address pins are 0. The byte's address is then driven for 2U cycles before the strobe rises.
- R4: The strobe stays high for exactly 2U cycles with the address held. It then stays low for 2U cycles with the address still held before the next byte begins.
- R5: The byte addresses are start, start+1, and so on, wrapping modulo 2^ADDR_W. Exactly as many bytes are read as the count asks for, and a count of 2^ADDR_W reads every byte.
- R6: For each byte, `rd_valid_o` is a one-cycle pulse in the cycle right after the strobe's last high cycle. With it, `rd_data_o` holds the data byte present during that last high cycle and `rd_index_o` holds the byte's 0-based position in the run.
- R7: After the last byte's strobe-low interval, chip select bar stays 0 with load 1 for 2U cycles. It then goes to 1 with load 0 for U cycles, and `done_o` then pulses for one cycle. For n bytes, done comes 2+5U+n(1+6U) cycles after the accepting edge.
- R8: A start with a count of 0 raises `done_o` for one cycle in the very next cycle. It causes no strobe, no chip select and no stream beat.
- R9: `busy_o` is 1 from the cycle after an accepted start up to and including the `done_o` cycle, and is 0 at all other times.
- R10: A start request that arrives while `busy_o` is 1, including during the `done_o` cycle, is ignored.
- R11: The strobe is high only while chip select bar is 0 and load is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled while idle |
| start_addr_i | input | ADDR_W | First byte address |
| len_i | input | ADDR_W+1 | Number of bytes to read |
| fuse_dout_i | input | 8 | Data byte from the fuse macro |
| fuse_csb_o | output | 1 | Macro chip select, active low |
| fuse_load_o | output | 1 | Macro read/load enable |
| fuse_pgenb_o | output | 1 | Macro program enable, active low, held 1 |
| fuse_addr_o | output | ADDR_W | Macro byte address |
| fuse_strobe_o | output | 1 | Macro read strobe |
| rd_valid_o | output | 1 | Stream beat valid pulse |
| rd_data_o | output | 8 | Byte read from the macro |
| rd_index_o | output | ADDR_W+1 | 0-based position of the byte in the run |
| busy_o | output | 1 | A read sequence is in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Every start address of the 32-byte array is tried with counts of 0, 1, 2 and 3. Counts 0 and 1 separate the zero-length shortcut and the framing around a single byte. Counts 2 and 3 expose the transition from one byte to the next and the address increment. Starts near the top of the array with longer counts, plus one full 32-byte read, test the wrap of the address while the index keeps counting. Starts injected in the middle of a burst and in its done cycle show that a busy sequencer keeps its schedule, because every pin is compared cycle by cycle against a timeline the bench computes arithmetically from U.

// File: rtl/fuse_rd_pkg.sv
`timescale 1ns/1ps
package fuse_rd_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SELECT,
        ST_POWER_UP,
        ST_ADDR_CLR,
        ST_ADDR_SET,
        ST_STROBE_HI,
        ST_STROBE_LO,
        ST_TAIL,
        ST_DESELECT,
        ST_FINISH
    } seq_state_e;

endpackage

// File: rtl/fuse_rd_timer.sv
`timescale 1ns/1ps
// Down-counting wait timer: loaded on every state change, expired at zero.
module fuse_rd_timer #(
    parameter int TMR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [TMR_W-1:0] load_val_i,
    output logic             expired_o
);

    logic [TMR_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/fuse_rd_cursor.sv
`timescale 1ns/1ps
// Tracks the current address, remaining count and position; captures data.
module fuse_rd_cursor #(
    parameter int ADDR_W = 5,
    parameter int CNT_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [CNT_W-1:0]  len_i,
    input  logic              sample_i,
    input  logic              advance_i,
    input  logic [7:0]        dout_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              last_o,
    output logic              len_zero_o,
    output logic              rd_valid_o,
    output logic [7:0]        rd_data_o,
    output logic [CNT_W-1:0]  rd_index_o
);

    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  remain_q;
    logic [CNT_W-1:0]  pos_q;
    logic              valid_q;
    logic [7:0]        data_q;
    logic [CNT_W-1:0]  index_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            remain_q <= '0;
            pos_q    <= '0;
        end else if (accept_i) begin
            addr_q   <= start_addr_i;
            remain_q <= len_i;
            pos_q    <= '0;
        end else if (advance_i) begin
            addr_q   <= addr_q + 1'b1;
            remain_q <= remain_q - 1'b1;
            pos_q    <= pos_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            data_q  <= '0;
            index_q <= '0;
        end else begin
            valid_q <= sample_i;
            if (sample_i) begin
                data_q  <= dout_i;
                index_q <= pos_q;
            end
        end
    end

    assign addr_o     = addr_q;
    assign last_o     = (remain_q == CNT_W'(1));
    assign len_zero_o = (len_i == '0);
    assign rd_valid_o = valid_q;
    assign rd_data_o  = data_q;
    assign rd_index_o = index_q;

endmodule

// File: rtl/fuse_rd_fsm.sv
`timescale 1ns/1ps
// Sequencing state machine: owns the state register and the wait lengths.
module fuse_rd_fsm
    import fuse_rd_pkg::*;
#(
    parameter int CYCLES_PER_US = 4,
    parameter int TMR_W         = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             len_zero_i,
    input  logic             last_i,
    input  logic             tmr_expired_i,
    output seq_state_e       state_o,
    output logic             tmr_load_o,
    output logic [TMR_W-1:0] tmr_val_o,
    output logic             accept_o,
    output logic             sample_o,
    output logic             advance_o
);

    localparam int GAP_1US = CYCLES_PER_US;
    localparam int GAP_2US = 2 * CYCLES_PER_US;

    seq_state_e st_q;
    seq_state_e st_nxt;

    function automatic int dwell_of(seq_state_e s);
        case (s)
            ST_POWER_UP, ST_ADDR_SET, ST_STROBE_HI,
            ST_STROBE_LO, ST_TAIL:  return GAP_2US;
            ST_DESELECT:            return GAP_1US;
            default:                return 1;
        endcase
    endfunction

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_nxt;
        end
    end

    // Transitions
    always_comb begin
        st_nxt    = st_q;
        accept_o  = 1'b0;
        sample_o  = 1'b0;
        advance_o = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (start_i) begin
                    accept_o = 1'b1;
                    st_nxt   = len_zero_i ? ST_FINISH : ST_SELECT;
                end
            end
            ST_SELECT: begin
                if (tmr_expired_i) st_nxt = ST_POWER_UP;
            end
            ST_POWER_UP: begin
                if (tmr_expired_i) st_nxt = ST_ADDR_CLR;
            end
            ST_ADDR_CLR: begin
                if (tmr_expired_i) st_nxt = ST_ADDR_SET;
            end
            ST_ADDR_SET: begin
                if (tmr_expired_i) st_nxt = ST_STROBE_HI;
            end
            ST_STROBE_HI: begin
                if (tmr_expired_i) begin
                    sample_o = 1'b1;
                    st_nxt   = ST_STROBE_LO;
                end
            end
            ST_STROBE_LO: begin
                if (tmr_expired_i) begin
                    advance_o = 1'b1;
                    st_nxt    = last_i ? ST_TAIL : ST_ADDR_CLR;
                end
            end
            ST_TAIL: begin
                if (tmr_expired_i) st_nxt = ST_DESELECT;
            end
            ST_DESELECT: begin
                if (tmr_expired_i) st_nxt = ST_FINISH;
            end
            ST_FINISH: begin
                st_nxt = ST_IDLE;
            end
        endcase
    end

    assign tmr_load_o = (st_nxt != st_q);
    assign tmr_val_o  = TMR_W'(dwell_of(st_nxt) - 1);
    assign state_o    = st_q;

endmodule

// File: rtl/fuse_read_seq.sv
`timescale 1ns/1ps
// Fuse macro read sequencer top level.
module fuse_read_seq
    import fuse_rd_pkg::*;
#(
    parameter int ADDR_W        = 5,
    parameter int CYCLES_PER_US = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [ADDR_W:0]   len_i,
    input  logic [7:0]        fuse_dout_i,
    output logic              fuse_csb_o,
    output logic              fuse_load_o,
    output logic              fuse_pgenb_o,
    output logic [ADDR_W-1:0] fuse_addr_o,
    output logic              fuse_strobe_o,
    output logic              rd_valid_o,
    output logic [7:0]        rd_data_o,
    output logic [ADDR_W:0]   rd_index_o,
    output logic              busy_o,
    output logic              done_o
);

    localparam int CNT_W = ADDR_W + 1;
    localparam int TMR_W = $clog2(2 * CYCLES_PER_US + 1);

    seq_state_e        state;
    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_expired;
    logic              accept;
    logic              sample;
    logic              advance;
    logic [ADDR_W-1:0] cur_addr;
    logic              last_byte;
    logic              len_zero;

    fuse_rd_fsm #(
        .CYCLES_PER_US (CYCLES_PER_US),
        .TMR_W         (TMR_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .len_zero_i    (len_zero),
        .last_i        (last_byte),
        .tmr_expired_i (tmr_expired),
        .state_o       (state),
        .tmr_load_o    (tmr_load),
        .tmr_val_o     (tmr_val),
        .accept_o      (accept),
        .sample_o      (sample),
        .advance_o     (advance)
    );

    fuse_rd_timer #(
        .TMR_W (TMR_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_expired)
    );

    fuse_rd_cursor #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_cursor (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept_i     (accept),
        .start_addr_i (start_addr_i),
        .len_i        (len_i),
        .sample_i     (sample),
        .advance_i    (advance),
        .dout_i       (fuse_dout_i),
        .addr_o       (cur_addr),
        .last_o       (last_byte),
        .len_zero_o   (len_zero),
        .rd_valid_o   (rd_valid_o),
        .rd_data_o    (rd_data_o),
        .rd_index_o   (rd_index_o)
    );

    // Output decode from state
    always_comb begin
        fuse_csb_o    = 1'b1;
        fuse_load_o   = 1'b0;
        fuse_pgenb_o  = 1'b1;
        fuse_strobe_o = 1'b0;
        fuse_addr_o   = '0;
        unique case (state)
            ST_SELECT: begin
                fuse_csb_o = 1'b0;
            end
            ST_POWER_UP, ST_ADDR_CLR, ST_TAIL: begin
                fuse_csb_o  = 1'b0;
                fuse_load_o = 1'b1;
            end
            ST_ADDR_SET, ST_STROBE_LO: begin
                fuse_csb_o  = 1'b0;
                fuse_load_o = 1'b1;
                fuse_addr_o = cur_addr;
            end
            ST_STROBE_HI: begin
                fuse_csb_o    = 1'b0;
                fuse_load_o   = 1'b1;
                fuse_addr_o   = cur_addr;
                fuse_strobe_o = 1'b1;
            end
            ST_IDLE, ST_DESELECT, ST_FINISH: begin
                fuse_csb_o = 1'b1;
            end
        endcase
    end

    assign busy_o = (state != ST_IDLE);
    assign done_o = (state == ST_FINISH);

endmodule

// File: rtl/fuse_read_seq_chk.sv
`timescale 1ns/1ps
// Protocol checker bound to the sequencer top.
module fuse_read_seq_chk #(
    parameter int ADDR_W        = 5,
    parameter int CYCLES_PER_US = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              fuse_csb_o,
    input logic              fuse_load_o,
    input logic              fuse_pgenb_o,
    input logic [ADDR_W-1:0] fuse_addr_o,
    input logic              fuse_strobe_o,
    input logic              rd_valid_o,
    input logic              busy_o,
    input logic              done_o
);

    localparam int STB_LEN = 2 * CYCLES_PER_US;

    logic [15:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hi_cnt <= '0;
        else if (fuse_strobe_o) hi_cnt <= hi_cnt + 1'b1;
        else hi_cnt <= '0;
    end

    // R11: strobe only inside an active, loaded select window
    assert_strobe_framed_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_strobe_o |-> (!fuse_csb_o && fuse_load_o && fuse_pgenb_o));

    // R4: strobe high for exactly 2U cycles
    assert_strobe_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fuse_strobe_o) |-> (hi_cnt == 16'(STB_LEN)));

    // R4: address held while strobe stays high and as it falls
    assert_addr_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fuse_strobe_o || $fell(fuse_strobe_o)) && $past(fuse_strobe_o) |-> $stable(fuse_addr_o));

    // R3: address set up before the strobe rises
    assert_addr_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fuse_strobe_o) |-> $stable(fuse_addr_o));

    // R6: one-cycle beats, only while busy
    assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> (busy_o && !done_o) ##1 !rd_valid_o);

    // R7: done is a single-cycle pulse
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9: busy drops right after done
    assert_busy_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

    // R10: a start while busy and not finishing does not disturb busy
    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o && start_i) |=> busy_o);

endmodule

bind fuse_read_seq fuse_read_seq_chk #(
    .ADDR_W        (ADDR_W),
    .CYCLES_PER_US (CYCLES_PER_US)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .fuse_csb_o    (fuse_csb_o),
    .fuse_load_o   (fuse_load_o),
    .fuse_pgenb_o  (fuse_pgenb_o),
    .fuse_addr_o   (fuse_addr_o),
    .fuse_strobe_o (fuse_strobe_o),
    .rd_valid_o    (rd_valid_o),
    .busy_o        (busy_o),
    .done_o        (done_o)
);

// File: tb/tb_fuse_read_seq.sv
`timescale 1ns/1ps
module tb_fuse_read_seq;

    localparam int AW       = 5;
    localparam int CW       = AW + 1;
    localparam int U        = 4;
    localparam int W        = 2 * U;
    localparam int BYTE_CYC = 1 + 3 * W;
    localparam int DEPTH    = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] saddr = '0;
    logic [CW-1:0] len = '0;
    logic [7:0]    dout;
    logic          csb, load, pgenb, strobe, valid, busy, done;
    logic [AW-1:0] faddr;
    logic [7:0]    rdata;
    logic [CW-1:0] rindex;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] fuse_val(int a);
        return 8'((a * 53 + 29) ^ (a << 3));
    endfunction

    assign dout = strobe ? fuse_val(int'(faddr)) : 8'h00;

    fuse_read_seq #(.ADDR_W(AW), .CYCLES_PER_US(U)) dut (
        .clk (clk), .rst_n (rst_n), .start_i (start), .start_addr_i (saddr),
        .len_i (len), .fuse_dout_i (dout), .fuse_csb_o (csb), .fuse_load_o (load),
        .fuse_pgenb_o (pgenb), .fuse_addr_o (faddr), .fuse_strobe_o (strobe),
        .rd_valid_o (valid), .rd_data_o (rdata), .rd_index_o (rindex),
        .busy_o (busy), .done_o (done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Runs one burst and compares every pin against the computed timeline.
    task automatic run_burst(input int a, input int n, input int inject_at);
        int base, tail, total, beats;
        bit pin_ok, ctl_ok, beat_ok;
        int pin_act, pin_exp, ctl_act, ctl_exp, beat_act, beat_exp;
        string pin_req, ctl_req;
        base  = 2 + W;
        tail  = base + n * BYTE_CYC;
        total = (n == 0) ? 1 : tail + W + U;
        beats = 0;
        pin_ok = 1'b1; ctl_ok = 1'b1; beat_ok = 1'b1;
        pin_act = 0; pin_exp = 0; ctl_act = 0; ctl_exp = 0; beat_act = 0; beat_exp = 0;
        pin_req = "R2"; ctl_req = "R9";
        @(negedge clk);
        start = 1'b1; saddr = AW'(a); len = CW'(n);
        @(negedge clk);
        start = 1'b0;
        for (int k = 1; k <= total + 1; k++) begin
            logic e_csb, e_load, e_stb, e_busy, e_done, e_val;
            int e_addr, e_data, e_idx, j, r;
            string rq;
            e_csb = 1'b1; e_load = 1'b0; e_stb = 1'b0; e_addr = 0;
            e_busy = (k <= total); e_done = (k == total);
            e_val = 1'b0; e_data = 0; e_idx = 0; rq = "R1";
            if (n == 0) begin
                rq = "R8";
            end else if (k == 1) begin
                e_csb = 1'b0; rq = "R2";
            end else if (k < base) begin
                e_csb = 1'b0; e_load = 1'b1; rq = "R2";
            end else if (k < tail) begin
                e_csb = 1'b0; e_load = 1'b1;
                j = (k - base) / BYTE_CYC;
                r = (k - base) % BYTE_CYC;
                rq = (r <= W) ? "R3" : "R4";
                if (r >= 1) e_addr = (a + j) % DEPTH;
                if (r >= W + 1 && r <= 2 * W) e_stb = 1'b1;
                if (r == 2 * W + 1) begin
                    e_val = 1'b1; e_data = int'(fuse_val(e_addr)); e_idx = j;
                end
            end else if (k < tail + W) begin
                e_csb = 1'b0; e_load = 1'b1; rq = "R7";
            end else if (k <= total) begin
                rq = "R7";
            end
            if (pin_ok && ({csb, load, pgenb, strobe} != {e_csb, e_load, 1'b1, e_stb}
                           || int'(faddr) != e_addr)) begin
                pin_ok  = 1'b0;
                pin_req = (n > 0 && inject_at > 0) ? {rq, "/R10"} : rq;
                pin_act = int'({csb, load, pgenb, strobe}) * 256 + int'(faddr);
                pin_exp = int'({e_csb, e_load, 1'b1, e_stb}) * 256 + e_addr;
            end
            if (ctl_ok && (busy != e_busy || done != e_done)) begin
                ctl_ok  = 1'b0;
                ctl_req = (done != e_done) ? ((n == 0) ? "R8" : "R7") : "R9";
                ctl_act = int'({busy, done}) + 100 * k;
                ctl_exp = int'({e_busy, e_done}) + 100 * k;
            end
            if (valid) beats++;
            if (beat_ok && (valid != e_val ||
                (e_val && (int'(rdata) != e_data || int'(rindex) != e_idx)))) begin
                beat_ok  = 1'b0;
                beat_act = int'(valid) * 100000 + int'(rindex) * 256 + int'(rdata);
                beat_exp = int'(e_val) * 100000 + e_idx * 256 + e_data;
            end
            if (k == inject_at) begin
                start = 1'b1; saddr = ~AW'(a); len = CW'(3);
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check(pin_ok, pin_req, $sformatf("pin timeline a=%0d n=%0d", a, n), pin_act, pin_exp);
        check(ctl_ok, ctl_req, $sformatf("busy/done a=%0d n=%0d", a, n), ctl_act, ctl_exp);
        check(beat_ok, "R6", $sformatf("stream beat a=%0d n=%0d", a, n), beat_act, beat_exp);
        check(beats == n, "R5", $sformatf("byte count a=%0d", a), beats, n);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(csb == 1'b1 && load == 1'b0 && pgenb == 1'b1 && strobe == 1'b0,
              "R1", "pins in reset", int'({csb, load, pgenb, strobe}), 4'b1010);
        check(faddr == '0 && !busy && !done && !valid, "R1", "status in reset",
              int'({faddr, busy, done, valid}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(csb == 1'b1 && !busy && !done, "R1", "idle after reset",
              int'({csb, busy, done}), 3'b100);
        // Sweep all start addresses with short counts
        for (int a = 0; a < DEPTH; a++) begin
            for (int n = 0; n < 4; n++) begin
                run_burst(a, n, (n > 0 && (a % 4) == n) ? 7 : 0);
            end
        end
        // R5: wrap at the top of the array
        run_burst(29, 6, 0);
        run_burst(31, 2, 0);
        // R5: full-array read
        run_burst(0, DEPTH, 0);
        // R10: start during a strobe and during the done cycle
        run_burst(12, 2, 2 + W + W + 3);
        run_burst(31, 1, 2 + W + BYTE_CYC + W + U);
        // R8: zero length after a read
        run_burst(5, 0, 0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule